// File: doc/BRIEF.md
# Reconfigurable Array Processing Node

This block is a single word-level processing element meant to be tiled into a coarse-grained reconfigurable array. In every cycle it picks two data operands and one predicate bit from its neighbours, its own small register file, an immediate field, or its own previous output. It then runs one arithmetic, logic, shift, multiply or compare operation and registers the result on its outputs. It can also write the result back into its local register file.

There is no instruction stream inside the node. An external array controller presents a context index each cycle. That index selects one word from a local context memory. The word fixes the operation, every operand select, the predicate select, and the register-file read and write addresses.

The context memory is filled through a load port while the node is parked with its run enable low. Predicated execution lets loop bodies with branches run as straight-line code. A false predicate suppresses the data and register-file updates and clears both predicate outputs.

Top module: `cgra_pe`

## Requirements
- R1: While reset is active and afterwards, `dataOut`, `predOut1`, `predOut2` and every register-file entry are 0. Every context word is 0, which decodes as a no-operation.
- R2: The context index is presented in cycle t and the result appears on `dataOut` after the next rising edge. Opcodes 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR and 13 PASS (operand A) wrap at WIDTH bits.
- R3: For opcodes 6 SHL, 7 SHRL and 8 SHRA, only the low log2(WIDTH) bits of operand B form the shift amount. SHRA fills the vacated bits with the sign bit.
- R4: Opcodes 10 EQ, 11 signed less-than and 12 unsigned less-than set `predOut1` to the flag and `predOut2` to its complement, and write the zero-extended flag to `dataOut`. Every other executed operation drives both predicate outputs to 0.
- R5: When the selected predicate is 0 and the node runs, `dataOut` and the register file keep their values and both predicate outputs become 0.
- R6: While `runEn` is 0, all outputs hold and `cfgWe` writes `cfgData` into context `cfgAddr`. A write attempted while `runEn` is 1 is ignored.
- R7: The register file has four entries, two read ports (addresses A and B) and one write port gated by the context's write-enable bit. A value written at an edge is read in the following cycle; a read in the same cycle as a write to the same entry returns the old value.
- R8: Operand select codes are: 0 to 3 for neighbour n, 4 for the register-file read port (port A for operand A, port B for operand B), 5 for the immediate sign-extended from 8 bits, 6 for the node's own `dataOut`, and 7 for zero.
- R9: Predicate select codes are: 0 to 3 for neighbour predicate n, 4 for own `predOut1`, 5 for own `predOut2`, 6 for constant 1, and 7 for constant 0.
- R10: Opcode 9 MUL returns the low WIDTH bits of the product when HAS_MUL is 1, and 0 otherwise. Opcodes 0, 14 and 15 are no-operations: the data and register file hold and the predicates clear.
- R11: The 28-bit context word is laid out, MSB first, as opcode[27:24], operand-A select[23:21], operand-B select[20:18], predicate select[17:15], read address A[14:13], read address B[12:11], write address[10:9], write enable[8] and immediate[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Node executes contexts when 1; parked and loadable when 0 |
| ctxIdx | input | CTX_AW | Context selected for the current cycle |
| cfgWe | input | 1 | Context memory write strobe |
| cfgAddr | input | CTX_AW | Context memory write address |
| cfgData | input | 28 | Context word to store |
| nbrData | input | NUM_NBR*WIDTH | Neighbour data outputs, neighbour n in bits [n*WIDTH +: WIDTH] |
| nbrPred | input | NUM_NBR | Neighbour predicate outputs |
| dataOut | output | WIDTH | Registered data result |
| predOut1 | output | 1 | Registered first predicate destination |
| predOut2 | output | 1 | Registered second predicate destination |

## Verification
The interesting collision is a register-file write and a register-file read of the same entry in one cycle. One context adds the immediate to entry 2 and writes the sum back to entry 2. A following context reads entry 2 on both ports. The bench expects the first result to use the old value and the second to use the new one.

A second collision is a configuration write presented while the node is running a context. The bench asserts `cfgWe` during an executing cycle, then runs the targeted context and expects its old behaviour on `dataOut`.

// File: rtl/cgra_pe_pkg.sv
package cgra_pe_pkg;

  localparam int RF_AW    = 2;
  localparam int RF_DEPTH = 1 << RF_AW;
  localparam int SEL_W    = 3;
  localparam int IMM_W    = 8;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_ADD    = 4'd1,
    OP_SUB    = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_XOR    = 4'd5,
    OP_SHL    = 4'd6,
    OP_SHRL   = 4'd7,
    OP_SHRA   = 4'd8,
    OP_MUL    = 4'd9,
    OP_CMPEQ  = 4'd10,
    OP_CMPLTS = 4'd11,
    OP_CMPLTU = 4'd12,
    OP_PASS   = 4'd13,
    OP_RSV14  = 4'd14,
    OP_RSV15  = 4'd15
  } opcode_e;

  // operand select codes above the neighbour range
  localparam logic [SEL_W-1:0] SRC_RF   = 3'd4;
  localparam logic [SEL_W-1:0] SRC_IMM  = 3'd5;
  localparam logic [SEL_W-1:0] SRC_SELF = 3'd6;
  localparam logic [SEL_W-1:0] SRC_ZERO = 3'd7;

  // predicate select codes above the neighbour range
  localparam logic [SEL_W-1:0] PSEL_OWN1 = 3'd4;
  localparam logic [SEL_W-1:0] PSEL_OWN2 = 3'd5;
  localparam logic [SEL_W-1:0] PSEL_ONE  = 3'd6;
  localparam logic [SEL_W-1:0] PSEL_ZERO = 3'd7;

  typedef struct packed {
    opcode_e            op;
    logic [SEL_W-1:0]   srcASel;
    logic [SEL_W-1:0]   srcBSel;
    logic [SEL_W-1:0]   predSel;
    logic [RF_AW-1:0]   rdAddrA;
    logic [RF_AW-1:0]   rdAddrB;
    logic [RF_AW-1:0]   wrAddr;
    logic               wrEn;
    logic [IMM_W-1:0]   imm;
  } ctx_t;

  localparam int CTX_W = $bits(ctx_t);

  // strobes from control to datapath
  typedef struct packed {
    logic               advance;
    logic               commit;
    logic               rfWrite;
    logic               cmpOp;
    opcode_e            op;
    logic [SEL_W-1:0]   srcASel;
    logic [SEL_W-1:0]   srcBSel;
    logic [RF_AW-1:0]   rdAddrA;
    logic [RF_AW-1:0]   rdAddrB;
    logic [RF_AW-1:0]   wrAddr;
    logic [IMM_W-1:0]   imm;
  } strobe_t;

endpackage

// File: rtl/cgra_pe_ctrl.sv
module cgra_pe_ctrl
  import cgra_pe_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int NUM_NBR = 4,
  localparam int CTX_AW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [CTX_AW-1:0] ctxIdx,
  input  logic              cfgWe,
  input  logic [CTX_AW-1:0] cfgAddr,
  input  logic [CTX_W-1:0]  cfgData,
  input  logic [NUM_NBR-1:0] nbrPred,
  input  logic              ownPred1,
  input  logic              ownPred2,
  output strobe_t           stb,
  output logic              predIn
);

  ctx_t ctxMem [NUM_CTX];
  ctx_t cur;
  logic isNop;
  logic isCmp;
  logic cfgInRange;
  logic idxInRange;

  assign cfgInRange = {1'b0, cfgAddr} < (CTX_AW + 1)'(NUM_CTX);
  assign idxInRange = {1'b0, ctxIdx}  < (CTX_AW + 1)'(NUM_CTX);

  // context storage: loadable only while parked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CTX; i++) ctxMem[i] <= '0;
    end else if (cfgWe && !runEn && cfgInRange) begin
      ctxMem[cfgAddr] <= ctx_t'(cfgData);
    end
  end

  assign cur = idxInRange ? ctxMem[ctxIdx] : '0;

  // predicate input multiplexer
  always_comb begin
    predIn = 1'b0;
    case (cur.predSel)
      PSEL_OWN1: predIn = ownPred1;
      PSEL_OWN2: predIn = ownPred2;
      PSEL_ONE:  predIn = 1'b1;
      PSEL_ZERO: predIn = 1'b0;
      default: begin
        for (int n = 0; n < NUM_NBR; n++)
          if (cur.predSel == SEL_W'(n)) predIn = nbrPred[n];
      end
    endcase
  end

  always_comb begin
    isNop = cur.op inside {OP_NOP, OP_RSV14, OP_RSV15};
    isCmp = cur.op inside {OP_CMPEQ, OP_CMPLTS, OP_CMPLTU};
    stb.advance = runEn;
    stb.commit  = runEn && predIn && !isNop;
    stb.rfWrite = runEn && predIn && !isNop && cur.wrEn;
    stb.cmpOp   = isCmp;
    stb.op      = cur.op;
    stb.srcASel = cur.srcASel;
    stb.srcBSel = cur.srcBSel;
    stb.rdAddrA = cur.rdAddrA;
    stb.rdAddrB = cur.rdAddrB;
    stb.wrAddr  = cur.wrAddr;
    stb.imm     = cur.imm;
  end

endmodule

// File: rtl/cgra_pe_dp.sv
module cgra_pe_dp
  import cgra_pe_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int NUM_NBR = 4,
  parameter bit HAS_MUL = 1'b1,
  localparam int SH_W   = $clog2(WIDTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [NUM_NBR*WIDTH-1:0] nbrData,
  output logic [WIDTH-1:0]         dataOut,
  output logic                     predOut1,
  output logic                     predOut2
);

  logic [WIDTH-1:0] rf [RF_DEPTH];
  logic [WIDTH-1:0] immExt;
  logic [WIDTH-1:0] opndA;
  logic [WIDTH-1:0] opndB;
  logic [WIDTH-1:0] mulRes;
  logic [WIDTH-1:0] aluRes;
  logic [SH_W-1:0]  shAmt;
  logic             cmpFlag;

  assign immExt = {{(WIDTH - IMM_W){stb.imm[IMM_W-1]}}, stb.imm};

  // two identical operand multiplexers, one per source port
  for (genvar p = 0; p < 2; p++) begin : g_opnd
    logic [SEL_W-1:0] sel;
    logic [RF_AW-1:0] rdAddr;
    logic [WIDTH-1:0] val;
    assign sel    = (p == 0) ? stb.srcASel : stb.srcBSel;
    assign rdAddr = (p == 0) ? stb.rdAddrA : stb.rdAddrB;
    always_comb begin
      val = '0;
      case (sel)
        SRC_RF:   val = rf[rdAddr];
        SRC_IMM:  val = immExt;
        SRC_SELF: val = dataOut;
        SRC_ZERO: val = '0;
        default: begin
          for (int n = 0; n < NUM_NBR; n++)
            if (sel == SEL_W'(n)) val = nbrData[n*WIDTH +: WIDTH];
        end
      endcase
    end
  end

  assign opndA = g_opnd[0].val;
  assign opndB = g_opnd[1].val;
  assign shAmt = opndB[SH_W-1:0];

  if (HAS_MUL) begin : g_mul
    assign mulRes = WIDTH'(opndA * opndB);
  end else begin : g_nomul
    assign mulRes = '0;
  end

  always_comb begin
    aluRes  = '0;
    cmpFlag = 1'b0;
    case (stb.op)
      OP_ADD:    aluRes = opndA + opndB;
      OP_SUB:    aluRes = opndA - opndB;
      OP_AND:    aluRes = opndA & opndB;
      OP_OR:     aluRes = opndA | opndB;
      OP_XOR:    aluRes = opndA ^ opndB;
      OP_SHL:    aluRes = opndA << shAmt;
      OP_SHRL:   aluRes = opndA >> shAmt;
      OP_SHRA:   aluRes = $signed(opndA) >>> shAmt;
      OP_MUL:    aluRes = mulRes;
      OP_CMPEQ:  cmpFlag = (opndA == opndB);
      OP_CMPLTS: cmpFlag = ($signed(opndA) < $signed(opndB));
      OP_CMPLTU: cmpFlag = (opndA < opndB);
      OP_PASS:   aluRes = opndA;
      default:   aluRes = '0;
    endcase
    if (stb.cmpOp) aluRes = {{(WIDTH - 1){1'b0}}, cmpFlag};
  end

  // output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      predOut1 <= 1'b0;
      predOut2 <= 1'b0;
    end else if (stb.advance) begin
      predOut1 <= stb.commit && stb.cmpOp && cmpFlag;
      predOut2 <= stb.commit && stb.cmpOp && !cmpFlag;
      if (stb.commit) dataOut <= aluRes;
    end
  end

  // local register file, single write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RF_DEPTH; i++) rf[i] <= '0;
    end else if (stb.rfWrite) begin
      rf[stb.wrAddr] <= aluRes;
    end
  end

endmodule

// File: rtl/cgra_pe.sv
module cgra_pe
  import cgra_pe_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int NUM_NBR = 4,
  parameter int NUM_CTX = 8,
  parameter bit HAS_MUL = 1'b1,
  localparam int CTX_AW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     runEn,
  input  logic [CTX_AW-1:0]        ctxIdx,
  input  logic                     cfgWe,
  input  logic [CTX_AW-1:0]        cfgAddr,
  input  logic [CTX_W-1:0]         cfgData,
  input  logic [NUM_NBR*WIDTH-1:0] nbrData,
  input  logic [NUM_NBR-1:0]       nbrPred,
  output logic [WIDTH-1:0]         dataOut,
  output logic                     predOut1,
  output logic                     predOut2
);

  strobe_t stb;
  logic    predIn;

  cgra_pe_ctrl #(
    .NUM_CTX (NUM_CTX),
    .NUM_NBR (NUM_NBR)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .ctxIdx   (ctxIdx),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .nbrPred  (nbrPred),
    .ownPred1 (predOut1),
    .ownPred2 (predOut2),
    .stb      (stb),
    .predIn   (predIn)
  );

  cgra_pe_dp #(
    .WIDTH   (WIDTH),
    .NUM_NBR (NUM_NBR),
    .HAS_MUL (HAS_MUL)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .nbrData  (nbrData),
    .dataOut  (dataOut),
    .predOut1 (predOut1),
    .predOut2 (predOut2)
  );

endmodule

// File: rtl/cgra_pe_chk.sv
module cgra_pe_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             predIn,
  input logic             cmpNow,
  input logic             rfWrite,
  input logic [WIDTH-1:0] dataOut,
  input logic             predOut1,
  input logic             predOut2
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // parked node keeps every output
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !$past(runEn) |-> ($stable(dataOut) && $stable(predOut1) && $stable(predOut2)));

  // false predicate blocks the data update and clears predicates
  assert_pred_block_R5: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(runEn) && !$past(predIn)) |-> ($stable(dataOut) && !predOut1 && !predOut2));

  // an executed compare yields complementary predicates and a flag on the data
  assert_cmp_pair_R4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $past(runEn && predIn && cmpNow) |->
      ((predOut1 != predOut2) && (dataOut == {{(WIDTH-1){1'b0}}, predOut1})));

  // non-compare steps leave both predicates low
  assert_no_pred_R4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(runEn) && !$past(cmpNow)) |-> (!predOut1 && !predOut2));

  // no register-file write while parked
  assert_rf_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !rfWrite);

endmodule

bind cgra_pe cgra_pe_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .runEn    (runEn),
  .predIn   (predIn),
  .cmpNow   (stb.cmpOp),
  .rfWrite  (stb.rfWrite),
  .dataOut  (dataOut),
  .predOut1 (predOut1),
  .predOut2 (predOut2)
);

// File: tb/cgra_pe_tb_top.sv
module cgra_pe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int NN = 4;

  typedef struct packed {
    logic [2:0]  ctx;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] expD;
    logic        expP1;
    logic        expP2;
  } vec_t;

  // contexts 0..7 loaded below: ADD SUB XOR SHL SHRA SHRL CMPLTS CMPLTU
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 32'd5,          32'd7,          32'd12,         1'b0, 1'b0},
    '{3'd0, 32'hFFFF_FFFF,  32'd2,          32'd1,          1'b0, 1'b0},
    '{3'd1, 32'd3,          32'd5,          32'hFFFF_FFFE,  1'b0, 1'b0},
    '{3'd2, 32'hF0F0_F0F0,  32'hFF00_FF00,  32'h0FF0_0FF0,  1'b0, 1'b0},
    '{3'd3, 32'd1,          32'd33,         32'd2,          1'b0, 1'b0},
    '{3'd4, 32'h8000_0000,  32'd4,          32'hF800_0000,  1'b0, 1'b0},
    '{3'd5, 32'h8000_0000,  32'd36,         32'h0800_0000,  1'b0, 1'b0},
    '{3'd6, 32'hFFFF_FFFF,  32'd1,          32'd1,          1'b1, 1'b0},
    '{3'd7, 32'hFFFF_FFFF,  32'd1,          32'd0,          1'b0, 1'b1},
    '{3'd6, 32'd5,          32'd5,          32'd0,          1'b0, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            runEn = 1'b0;
  logic [2:0]      ctxIdx = '0;
  logic            cfgWe = 1'b0;
  logic [2:0]      cfgAddr = '0;
  logic [27:0]     cfgData = '0;
  logic [NN*W-1:0] nbrData = '0;
  logic [NN-1:0]   nbrPred = '0;
  logic [W-1:0]    dataOut;
  logic            predOut1;
  logic            predOut2;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cgra_pe dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .ctxIdx   (ctxIdx),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .nbrData  (nbrData),
    .nbrPred  (nbrPred),
    .dataOut  (dataOut),
    .predOut1 (predOut1),
    .predOut2 (predOut2)
  );

  function automatic logic [27:0] mkCtx(logic [3:0] op, logic [2:0] sa, logic [2:0] sb,
                                        logic [2:0] ps, logic [1:0] ra, logic [1:0] rb,
                                        logic [1:0] wa, logic we, logic [7:0] imm);
    return {op, sa, sb, ps, ra, rb, wa, we, imm};
  endfunction

  task automatic setNbr(int n, logic [W-1:0] v);
    nbrData[n*W +: W] = v;
  endtask

  task automatic cfgWrite(int addr, logic [27:0] w);
    cfgWe = 1'b1; cfgAddr = 3'(addr); cfgData = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic stepRun(int idx);
    runEn = 1'b1; ctxIdx = 3'(idx);
    @(negedge clk);
  endtask

  task automatic checkOut(string req, logic [W-1:0] expD, logic expP1, logic expP2);
    nChecks++;
    if (dataOut !== expD || predOut1 !== expP1 || predOut2 !== expP2) begin
      nErrors++;
      $display("FAIL %s: data=%h p1=%b p2=%b expected data=%h p1=%b p2=%b",
               req, dataOut, predOut1, predOut2, expD, expP1, expP2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 during reset", '0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", '0, 1'b0, 1'b0);

    // unloaded contexts are no-operations
    setNbr(0, 32'h1111); setNbr(1, 32'h2222);
    stepRun(3);
    checkOut("R1 empty context is NOP", '0, 1'b0, 1'b0);

    // phase 1: operation table (R11 layout)
    runEn = 1'b0;
    cfgWrite(0, mkCtx(4'd1,  3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b1, 8'h00));
    cfgWrite(1, mkCtx(4'd2,  3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(2, mkCtx(4'd5,  3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(3, mkCtx(4'd6,  3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(4, mkCtx(4'd8,  3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(5, mkCtx(4'd7,  3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(6, mkCtx(4'd11, 3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(7, mkCtx(4'd12, 3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));

    for (int i = 0; i < NVEC; i++) begin
      setNbr(0, VECS[i].a); setNbr(1, VECS[i].b);
      stepRun(int'(VECS[i].ctx));
      checkOut($sformatf("R2/R3/R4 vector %0d", i), VECS[i].expD, VECS[i].expP1, VECS[i].expP2);
    end

    // parked: outputs hold despite new inputs
    runEn = 1'b0;
    setNbr(0, 32'd100); setNbr(1, 32'd1);
    @(negedge clk);
    checkOut("R6 hold while parked", 32'd0, 1'b0, 1'b1);

    // phase 2: register file, operand and predicate selects (R11 layout)
    cfgWrite(0, mkCtx(4'd13, 3'd5, 3'd7, 3'd6, 2'd0, 2'd0, 2'd2, 1'b1, 8'h55));
    cfgWrite(1, mkCtx(4'd1,  3'd4, 3'd4, 3'd6, 2'd2, 2'd2, 2'd0, 1'b0, 8'h00));
    cfgWrite(2, mkCtx(4'd1,  3'd5, 3'd4, 3'd6, 2'd0, 2'd2, 2'd2, 1'b1, 8'hFF));
    cfgWrite(3, mkCtx(4'd1,  3'd6, 3'd3, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(4, mkCtx(4'd4,  3'd2, 3'd7, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(5, mkCtx(4'd1,  3'd0, 3'd1, 3'd1, 2'd0, 2'd0, 2'd3, 1'b1, 8'h00));
    cfgWrite(6, mkCtx(4'd10, 3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(7, mkCtx(4'd13, 3'd4, 3'd7, 3'd6, 2'd3, 2'd0, 2'd0, 1'b0, 8'h00));

    stepRun(0);
    checkOut("R8 immediate into R7 entry 2", 32'h55, 1'b0, 1'b0);
    stepRun(1);
    checkOut("R7 both read ports", 32'hAA, 1'b0, 1'b0);
    stepRun(2);
    checkOut("R7 same-cycle read sees old entry", 32'h54, 1'b0, 1'b0);
    stepRun(1);
    checkOut("R7 write visible next cycle", 32'hA8, 1'b0, 1'b0);
    setNbr(3, 32'd2);
    stepRun(3);
    checkOut("R8 own output feedback", 32'hAA, 1'b0, 1'b0);
    setNbr(2, 32'h1234_5678);
    stepRun(4);
    checkOut("R8 neighbour 2 and zero source", 32'h1234_5678, 1'b0, 1'b0);
    setNbr(0, 32'd9); setNbr(1, 32'd9);
    stepRun(6);
    checkOut("R4 equal compare", 32'd1, 1'b1, 1'b0);
    nbrPred = 4'b0000;
    setNbr(0, 32'd4); setNbr(1, 32'd5);
    stepRun(5);
    checkOut("R5 false predicate holds data", 32'd1, 1'b0, 1'b0);
    stepRun(7);
    checkOut("R5 register file untouched", 32'd0, 1'b0, 1'b0);
    nbrPred = 4'b0010;
    stepRun(5);
    checkOut("R9 neighbour predicate 1 enables", 32'd9, 1'b0, 1'b0);
    stepRun(7);
    checkOut("R7 entry 3 written", 32'd9, 1'b0, 1'b0);

    // phase 3: multiply, AND, locked configuration
    runEn = 1'b0;
    cfgWrite(0, mkCtx(4'd9, 3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    cfgWrite(2, mkCtx(4'd3, 3'd0, 3'd1, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00));
    setNbr(0, 32'h0001_0000); setNbr(1, 32'h0001_0001);
    stepRun(0);
    checkOut("R10 multiply low half", 32'h0001_0000, 1'b0, 1'b0);
    setNbr(0, 32'hFF00_FF00); setNbr(1, 32'h0FF0_0FF0);
    stepRun(2);
    checkOut("R2 AND", 32'h0F00_0F00, 1'b0, 1'b0);

    // load attempt while running must be dropped
    cfgWe = 1'b1; cfgAddr = 3'd1;
    cfgData = mkCtx(4'd13, 3'd5, 3'd7, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 8'h11);
    stepRun(2);
    cfgWe = 1'b0;
    checkOut("R6 running during load attempt", 32'h0F00_0F00, 1'b0, 1'b0);
    stepRun(1);
    checkOut("R6 load while running ignored", 32'hA8, 1'b0, 1'b0);

    runEn = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule